// File: doc/BRIEF.md
# Overvoltage Event Filter Counter

This block sits between a per-cycle overvoltage comparison and the fault supervisor of a switched-mode power controller. It declares a true overvoltage fault only when the over-threshold condition persists. Once per switching cycle, at the end of the secondary stroke, the comparison logic presents a one-cycle sample strobe together with a flag. The flag is high when the sensed output voltage was above the trip threshold in that cycle.

A saturating level counter accumulates the samples. A flagged sample adds one. A clean sample removes two, with a floor at zero. Isolated transients, such as an electrostatic discharge or a surge, therefore drain away faster than they build up. When the level reaches the trip value, the fault output latches high so that the supervisor can turn the switch off. A clear input, pulsed by the supervisor on restart, releases the fault and empties the counter.

Top module: `ovp_filter`

## Requirements
- R1: After reset the fault output is low and the level is zero, so exactly TRIP_COUNT flagged samples (default 10) are needed before the fault is raised.
- R2: A sample with valid high and flag high raises the level by one. The fault output goes high on the clock edge that registers the sample bringing the level to TRIP_COUNT, and not earlier.
- R3: A sample with valid high and flag low lowers the level by two.
- R4: The level never goes below zero. A clean sample taken at level 0 or 1 leaves the level at zero.
- R5: A clock cycle with valid low leaves the level and the fault unchanged, whatever the value of the flag.
- R6: Once the fault output is high, it stays high and the level stays at TRIP_COUNT. Samples of either flag value are ignored until the clear input is asserted.
- R7: Asserting the clear input for one cycle drives the fault low and the level to zero on the next edge. The clear takes priority over a sample presented in the same cycle.
- R8: A sequence in which every flagged sample is followed by at least one clean sample never raises the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe, once per switching cycle at the end of the secondary stroke |
| ov_flag_i | input | 1 | Overvoltage comparison result for this cycle, qualified by sample_valid_i |
| clear_i | input | 1 | Supervisor restart pulse; empties the counter and releases the fault |
| fault_o | output | 1 | Latched overvoltage fault |

## Verification
The assertions assume the following about the inputs:
- ov_flag_i is meaningful only when sample_valid_i is high.
- Strobes may arrive on any cycle, even back to back.
- The clear input may coincide with a strobe.

The bench keeps to these assumptions. It drives sample_valid_i, ov_flag_i and clear_i on falling edges for exactly one cycle per sample. It deliberately sets the flag high while the strobe is low to show that the flag alone has no effect. It also overlaps a clear with a flagged strobe to test the stated priority. The level is not a port, so the bench infers it from how many further flagged samples are needed to raise the fault.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    // Per-cycle action applied to the filter level
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_CLEAR = 2'd3
    } step_e;

endpackage

// File: rtl/ovf_step_decode.sv
module ovf_step_decode
    import ovf_pkg::*;
(
    input  logic  clear_i,
    input  logic  fault_i,
    input  logic  sample_valid_i,
    input  logic  ov_flag_i,
    output step_e step_o
);

    // Priority: clear, then frozen while faulted, then sample
    always_comb begin
        if (clear_i) begin
            step_o = STEP_CLEAR;
        end else if (fault_i) begin
            step_o = STEP_HOLD;
        end else if (sample_valid_i && ov_flag_i) begin
            step_o = STEP_UP;
        end else if (sample_valid_i) begin
            step_o = STEP_DOWN;
        end else begin
            step_o = STEP_HOLD;
        end
    end

endmodule

// File: rtl/ovf_sat_counter.sv
module ovf_sat_counter
    import ovf_pkg::*;
#(
    parameter int TRIP_COUNT = 10,
    parameter int UP_STEP    = 1,
    parameter int DOWN_STEP  = 2,
    localparam int CNT_W     = $clog2(TRIP_COUNT + 1)
) (
    input  step_e            step_i,
    input  logic [CNT_W-1:0] level_i,
    output logic [CNT_W-1:0] level_o,
    output logic             at_trip_o
);

    localparam logic [CNT_W-1:0] TRIP_V   = CNT_W'(TRIP_COUNT);
    localparam logic [CNT_W-1:0] UP_V     = CNT_W'(UP_STEP);
    localparam logic [CNT_W-1:0] DOWN_V   = CNT_W'(DOWN_STEP);
    localparam logic [CNT_W-1:0] UP_LIMIT = CNT_W'(TRIP_COUNT - UP_STEP);

    always_comb begin
        unique case (step_i)
            STEP_CLEAR: level_o = '0;
            STEP_UP:    level_o = (level_i >= UP_LIMIT) ? TRIP_V : level_i + UP_V;
            STEP_DOWN:  level_o = (level_i <= DOWN_V) ? '0 : level_i - DOWN_V;
            default:    level_o = level_i;
        endcase
    end

    assign at_trip_o = (level_o == TRIP_V);

endmodule

// File: rtl/ovp_filter.sv
module ovp_filter
    import ovf_pkg::*;
#(
    parameter int TRIP_COUNT = 10,
    parameter int UP_STEP    = 1,
    parameter int DOWN_STEP  = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sample_valid_i,
    input  logic ov_flag_i,
    input  logic clear_i,
    output logic fault_o
);

    localparam int CNT_W = $clog2(TRIP_COUNT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] level;
        logic             fault;
    } state_t;

    state_t           st_d, st_q;
    step_e            step;
    logic [CNT_W-1:0] level_nxt;
    logic             at_trip;
    logic [CNT_W-1:0] level_q;

    ovf_step_decode u_decode (
        .clear_i        (clear_i),
        .fault_i        (st_q.fault),
        .sample_valid_i (sample_valid_i),
        .ov_flag_i      (ov_flag_i),
        .step_o         (step)
    );

    ovf_sat_counter #(
        .TRIP_COUNT (TRIP_COUNT),
        .UP_STEP    (UP_STEP),
        .DOWN_STEP  (DOWN_STEP)
    ) u_count (
        .step_i    (step),
        .level_i   (st_q.level),
        .level_o   (level_nxt),
        .at_trip_o (at_trip)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = level_nxt;
        if (step == STEP_CLEAR) begin
            st_d.fault = 1'b0;
        end else begin
            st_d.fault = st_q.fault | at_trip;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_q = st_q.level;
    assign fault_o = st_q.fault;

endmodule

// File: rtl/ovp_filter_chk.sv
module ovp_filter_chk #(
    parameter int TRIP_COUNT = 10,
    localparam int CNT_W     = $clog2(TRIP_COUNT + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sample_valid_i,
    input logic             ov_flag_i,
    input logic             clear_i,
    input logic             fault_o,
    input logic [CNT_W-1:0] level_q
);

    // R2
    fault_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> $past(sample_valid_i && ov_flag_i && !clear_i));

    // R2
    level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_q <= CNT_W'(TRIP_COUNT));

    // R3
    clean_no_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_valid_i && !ov_flag_i && !clear_i && !fault_o) |=> !fault_o);

    // R5
    idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sample_valid_i && !clear_i) |=> ($stable(level_q) && $stable(fault_o)));

    // R6
    fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && !clear_i) |=> fault_o);

    // R7
    clear_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (!fault_o && level_q == '0));

endmodule

bind ovp_filter ovp_filter_chk #(.TRIP_COUNT(TRIP_COUNT)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .ov_flag_i      (ov_flag_i),
    .clear_i        (clear_i),
    .fault_o        (fault_o),
    .level_q        (level_q)
);

// File: tb/ovp_filter_tb.sv
module ovp_filter_tb;

    localparam int TRIP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0;
    logic flag = 1'b0;
    logic clear = 1'b0;
    logic fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ovp_filter #(.TRIP_COUNT(TRIP)) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .sample_valid_i (valid),
        .ov_flag_i      (flag),
        .clear_i        (clear),
        .fault_o        (fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s fault actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One sample; the result is visible at the following falling edge
    task automatic sample(input logic f);
        @(negedge clk);
        valid = 1'b1;
        flag  = f;
        @(negedge clk);
        valid = 1'b0;
        flag  = 1'b0;
    endtask

    task automatic ups(input int n);
        for (int i = 0; i < n; i++) sample(1'b1);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic t_reset_and_trip();
        check("R1 reset", fault, 1'b0);
        ups(TRIP - 1);
        check("R1 nine after reset", fault, 1'b0);
        ups(1);
        check("R2 trip at ten", fault, 1'b1);
    endtask

    task automatic t_sticky_and_clear();
        sample(1'b0);
        sample(1'b0);
        sample(1'b0);
        check("R6 clean samples ignored", fault, 1'b1);
        ups(2);
        check("R6 flagged samples ignored", fault, 1'b1);
        do_clear();
        check("R7 clear releases", fault, 1'b0);
        ups(TRIP - 1);
        check("R7 level zeroed", fault, 1'b0);
        ups(1);
        check("R7 retrip", fault, 1'b1);
        do_clear();
    endtask

    task automatic t_down_by_two();
        ups(TRIP - 1);
        sample(1'b0);
        ups(2);
        check("R3 level 9 after 9,-2,+2", fault, 1'b0);
        ups(1);
        check("R3 trip at level 10", fault, 1'b1);
        do_clear();
    endtask

    task automatic t_floor();
        ups(1);
        sample(1'b0);
        sample(1'b0);
        sample(1'b0);
        ups(TRIP - 1);
        check("R4 floor held, nine not enough", fault, 1'b0);
        ups(1);
        check("R4 trip after full ten", fault, 1'b1);
        do_clear();
    endtask

    task automatic t_idle();
        ups(TRIP - 1);
        @(negedge clk);
        flag = 1'b1;
        repeat (20) @(negedge clk);
        flag = 1'b0;
        check("R5 flag without strobe", fault, 1'b0);
        ups(1);
        check("R5 level kept through idle", fault, 1'b1);
        do_clear();
    endtask

    task automatic t_isolated();
        logic seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            sample(1'b1);
            sample(1'b0);
            seen = seen | fault;
        end
        for (int i = 0; i < 20; i++) begin
            sample(1'b1);
            sample(1'b1);
            sample(1'b0);
            seen = seen | fault;
        end
        check("R8 isolated events never trip", seen, 1'b0);
        ups(TRIP - 1);
        check("R8 level drained to zero", fault, 1'b0);
        ups(1);
        check("R8 then ten trips", fault, 1'b1);
        do_clear();
    endtask

    task automatic t_clear_priority();
        ups(TRIP - 1);
        @(negedge clk);
        clear = 1'b1;
        valid = 1'b1;
        flag  = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        valid = 1'b0;
        flag  = 1'b0;
        check("R7 clear beats strobe", fault, 1'b0);
        ups(TRIP - 1);
        check("R7 strobe under clear discarded", fault, 1'b0);
        ups(1);
        check("R7 trip after clear", fault, 1'b1);
        do_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_trip();
        t_sticky_and_clear();
        t_down_by_two();
        t_floor();
        t_idle();
        t_isolated();
        t_clear_priority();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule